// File: doc/BRIEF.md
# Dynamic Priority Interrupt Resolver

This block decides which interrupt line an interrupt controller should report next. It looks at up to three banks of 32 lines. For each line it receives a pending bit, an enable-mask bit, a class bit that marks the line as fast or normal, and a programmable priority number. A class-select input chooses whether the fast or the normal class is being arbitrated. From the lines that qualify, the block finds the winner and its global line index. It does this combinationally, and it also raises a flag whenever at least one line qualifies.

A one-cycle resolve strobe copies the current winner into a code register. If nothing qualifies, the value copied is zero. The surrounding controller pulses the strobe when it acknowledges an interrupt and then reads the held code. The bus interface, edge capture and output handshaking all stay in that controller.

Top module: `prio_resolver`

## Requirements
- R1: A line takes part only when its pending bit is 1, its mask bit is 0 (0 means enabled), and its class bit equals `sel_fast` (class bit 1 is fast, 0 is normal).
- R2: Among qualifying lines, the one with the numerically smallest priority wins. Priority 0 is the most urgent.
- R3: When several qualifying lines share the smallest priority, the line with the largest global index wins.
- R4: The global index of a line is 32 × bank + bit, where bank b occupies vector bits [32b+31:32b]. For example, bank 2 bit 5 is index 69.
- R5: When no line qualifies, `any_hit` is 0 and `win_idx` is 0. A resolve in that cycle loads 0 into `code_q`.
- R6: When `resolve` is 1 at a rising clock edge, `code_q` takes the winner that was present in that cycle. When `resolve` is 0, `code_q` holds its value even if the inputs change.
- R7: While `rst_n` is low, `code_q` is 0.
- R8: Each priority is `PRIO_W` bits wide. Line g uses `prio[g*PRIO_W +: PRIO_W]`, and every bit of the field, including the top one, takes part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend | input | NUM_BANKS*32 | Pending bit per line |
| mask | input | NUM_BANKS*32 | Mask bit per line, 1 disables the line |
| cls | input | NUM_BANKS*32 | Class bit per line, 1 fast, 0 normal |
| prio | input | NUM_BANKS*32*PRIO_W | Priority number per line, 0 most urgent |
| sel_fast | input | 1 | Class being arbitrated, 1 fast, 0 normal |
| resolve | input | 1 | Strobe that loads the winner into the code register |
| any_hit | output | 1 | At least one line qualifies |
| win_idx | output | clog2(NUM_BANKS*32) | Combinational winning global index |
| code_q | output | clog2(NUM_BANKS*32) | Registered code loaded by the strobe |

## Verification
Two functions can land in the same cycle: the resolve strobe latching a code, and the arbitration inputs changing to a new pattern. The bench creates this by driving a new pattern together with the strobe on one falling edge, and then driving a different pattern with the strobe low on the next falling edge. The scoreboard item for each cycle predicts that `code_q` carries the winner of the strobed pattern. After the later change, `code_q` must still carry that same value, while `win_idx` must already follow the new pattern.

// File: rtl/prio_resolver_pkg.sv
package prio_resolver_pkg;
  localparam int unsigned LINES_PER_BANK = 32;

  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned r;
    r = 1;
    while (r < n) r = r * 2;
    return r;
  endfunction
endpackage

// File: rtl/line_qualify.sv
module line_qualify #(
  parameter int unsigned N = 96
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] cls,
  input  logic         sel_fast,
  output logic [N-1:0] qual
);
  logic [N-1:0] class_match;

  always_comb begin
    class_match = sel_fast ? cls : ~cls;
    qual        = pend & ~mask & class_match;
  end
endmodule

// File: rtl/prio_tree.sv
module prio_tree
  import prio_resolver_pkg::*;
#(
  parameter int unsigned N      = 96,
  parameter int unsigned PRIO_W = 6,
  parameter int unsigned IDX_W  = 7
) (
  input  logic [N-1:0]        qual,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  localparam int unsigned LEAVES = pow2_ceil(N);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  // Heap layout: node k has children 2k (lower indices) and 2k+1 (higher).
  logic              nv [1:NODES];
  logic [PRIO_W-1:0] np [1:NODES];
  logic [IDX_W-1:0]  nx [1:NODES];

  genvar k;
  generate
    for (k = LEAVES; k <= NODES; k++) begin : g_leaf
      if ((k - LEAVES) < N) begin : g_real
        assign nv[k] = qual[k-LEAVES];
        assign np[k] = prio[(k-LEAVES)*PRIO_W +: PRIO_W];
        assign nx[k] = IDX_W'(k - LEAVES);
      end else begin : g_pad
        assign nv[k] = 1'b0;
        assign np[k] = '0;
        assign nx[k] = '0;
      end
    end
    for (k = 1; k < LEAVES; k++) begin : g_node
      logic take_hi;
      // Upper child wins ties, so equal priority resolves toward the top index.
      always_comb begin
        take_hi = nv[2*k+1] && (!nv[2*k] || (np[2*k+1] <= np[2*k]));
      end
      assign nv[k] = nv[2*k] | nv[2*k+1];
      assign np[k] = take_hi ? np[2*k+1] : np[2*k];
      assign nx[k] = take_hi ? nx[2*k+1] : nx[2*k];
    end
  endgenerate

  assign hit = nv[1];
  assign idx = nv[1] ? nx[1] : '0;
endmodule

// File: rtl/code_latch.sv
module code_latch #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] code_q
);
  logic [IDX_W-1:0] code_d;

  always_comb begin
    code_d = hit ? idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (load) begin
      code_q <= code_d;
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_resolver_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PRIO_W    = 6,
  localparam int unsigned N        = NUM_BANKS * LINES_PER_BANK,
  localparam int unsigned IDX_W    = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        pend,
  input  logic [N-1:0]        mask,
  input  logic [N-1:0]        cls,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic                sel_fast,
  input  logic                resolve,
  output logic                any_hit,
  output logic [IDX_W-1:0]    win_idx,
  output logic [IDX_W-1:0]    code_q
);
  logic [N-1:0] qual;

  line_qualify #(.N(N)) u_qual (
    .pend     (pend),
    .mask     (mask),
    .cls      (cls),
    .sel_fast (sel_fast),
    .qual     (qual)
  );

  prio_tree #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
    .qual (qual),
    .prio (prio),
    .hit  (any_hit),
    .idx  (win_idx)
  );

  code_latch #(.IDX_W(IDX_W)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (resolve),
    .hit    (any_hit),
    .idx    (win_idx),
    .code_q (code_q)
  );
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int unsigned N      = 96,
  parameter int unsigned PRIO_W = 6,
  parameter int unsigned IDX_W  = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        pend,
  input logic [N-1:0]        mask,
  input logic [N-1:0]        cls,
  input logic                sel_fast,
  input logic                resolve,
  input logic                any_hit,
  input logic [IDX_W-1:0]    win_idx,
  input logic [IDX_W-1:0]    code_q
);
  p_winner_qualifies_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (pend[win_idx] && !mask[win_idx] && (cls[win_idx] == sel_fast)));

  p_idle_index_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (win_idx == '0));

  p_index_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(win_idx) < N);

  p_code_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resolve |=> (code_q == $past(any_hit ? win_idx : '0)));

  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve |=> $stable(code_q));

  p_empty_loads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && !any_hit) |=> (code_q == '0));
endmodule

bind prio_resolver prio_resolver_chk #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pend     (pend),
  .mask     (mask),
  .cls      (cls),
  .sel_fast (sel_fast),
  .resolve  (resolve),
  .any_hit  (any_hit),
  .win_idx  (win_idx),
  .code_q   (code_q)
);

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb;
  localparam int NB = 3;
  localparam int PW = 6;
  localparam int N  = NB * 32;
  localparam int IW = $clog2(N);

  typedef struct {
    logic          any;
    logic [IW-1:0] idx;
    logic [IW-1:0] code;
    string         tag;
  } exp_t;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    pend, mask, cls;
  logic [N*PW-1:0] prio;
  logic            sel_fast, resolve;
  logic            any_hit;
  logic [IW-1:0]   win_idx, code_q;

  exp_t          q[$];
  int            n_vec  = 0;
  int            n_fail = 0;
  logic [IW-1:0] last_code;
  bit            done = 0;

  prio_resolver #(.NUM_BANKS(NB), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .cls(cls),
    .prio(prio), .sel_fast(sel_fast), .resolve(resolve),
    .any_hit(any_hit), .win_idx(win_idx), .code_q(code_q)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Reference winner: scan upward, "<=" lets a later line take an equal priority.
  task automatic ref_win(output logic any, output logic [IW-1:0] idx);
    int best;
    any  = 0;
    idx  = '0;
    best = 1 << PW;
    for (int g = 0; g < N; g++) begin
      if (pend[g] && !mask[g] && (cls[g] == sel_fast)) begin
        if (int'(prio[g*PW +: PW]) <= best) begin
          best = int'(prio[g*PW +: PW]);
          idx  = IW'(g);
          any  = 1;
        end
      end
    end
  endtask

  task automatic drive(input logic [N-1:0] p, input logic [N-1:0] m,
                       input logic [N-1:0] c, input logic [N*PW-1:0] pr,
                       input logic sf, input logic rs, input string tag);
    exp_t e;
    @(negedge clk);
    pend = p; mask = m; cls = c; prio = pr; sel_fast = sf; resolve = rs;
    #1;
    ref_win(e.any, e.idx);
    if (rs) last_code = e.any ? e.idx : '0;
    e.code = last_code;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one item per edge and compares with the design.
  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " any_hit"}, int'(any_hit), int'(e.any));
        check({e.tag, " win_idx"}, int'(win_idx), int'(e.idx));
        check({e.tag, " code_q"},  int'(code_q),  int'(e.code));
      end
    end
  end

  function automatic logic [N*PW-1:0] all_prio(input int v);
    logic [N*PW-1:0] r;
    for (int g = 0; g < N; g++) r[g*PW +: PW] = PW'(v);
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [N-1:0]    p, m, c;
    logic [N*PW-1:0] pr;
    rst_n = 0; pend = '0; mask = '1; cls = '0; prio = '0;
    sel_fast = 0; resolve = 0; last_code = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R7 reset code", int'(code_q), 0);
    @(negedge clk);
    rst_n = 1;

    // R4: single line in bank 2, bit 5 -> 69
    p = '0; p[69] = 1;
    drive(p, '0, '0, all_prio(7), 0, 1, "R4 bank2 bit5");
    // R6: same-cycle change: new pattern with strobe low; code must hold 69
    p = '0; p[3] = 1;
    drive(p, '0, '0, all_prio(7), 0, 0, "R6 hold after change");
    // R2: lower number wins over higher index
    p = '0; p[10] = 1; p[90] = 1; pr = all_prio(20); pr[10*PW +: PW] = 4;
    drive(p, '0, '0, pr, 0, 1, "R2 lower prio wins");
    // R3: all equal priorities, all pending -> top line
    drive('1, '0, '0, all_prio(9), 0, 1, "R3 equal all");
    // R3: equal priority across banks, top masked
    m = '0; m[95] = 1;
    drive('1, m, '0, all_prio(0), 0, 1, "R3 equal masked top");
    // R1: class select fast, only line 40 is fast
    c = '0; c[40] = 1;
    drive('1, '0, c, all_prio(1), 1, 1, "R1 fast class");
    // R1: normal class excludes fast lines
    c = '1; c[12] = 0;
    drive('1, '0, c, all_prio(1), 0, 1, "R1 normal class");
    // R5: everything masked
    drive('1, '1, '0, all_prio(1), 0, 1, "R5 all masked");
    // R5: nothing pending
    drive('0, '0, '0, all_prio(1), 1, 1, "R5 none pending");
    // R8: top priority bit counts: 31 beats 32
    p = '0; p[5] = 1; p[50] = 1; pr = all_prio(0);
    pr[5*PW +: PW] = 31; pr[50*PW +: PW] = 32;
    drive(p, '0, '0, pr, 0, 1, "R8 full width");
    // R6: strobe low with hits present keeps zero-free previous code
    drive('1, '0, '0, all_prio(2), 0, 0, "R6 hold strobe low");

    // Random patterns, some with all-equal priorities
    for (int t = 0; t < 400; t++) begin
      for (int w = 0; w < N; w += 32) begin
        p[w +: 32] = $urandom;
        m[w +: 32] = $urandom | $urandom;
        c[w +: 32] = $urandom;
      end
      if (t % 4 == 0) pr = all_prio($urandom % (1 << PW));
      else for (int g = 0; g < N; g++) pr[g*PW +: PW] = PW'($urandom);
      drive(p, m, c, pr, 1'($urandom), 1'(t % 3 != 2), "R2 R3 random");
    end

    @(negedge clk);
    resolve = 0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule